// File: doc/BRIEF.md
# Eight-Lane Sample Serializer with Alignment Patterns

This block takes one 12-bit sample for each of eight channels as a single parallel beat and sends every channel's sample out on its own serial line, least significant bit first, one bit per bit tick. All lanes share one bit counter, so their word boundaries coincide. Alongside the data it drives a bit clock that toggles once per transmitted bit, and a word clock that is high for the first half of every word and low for the second half. A receiver can use the word clock to locate each word boundary.

A 2-bit training select overrides the live samples on all lanes at once. The override can send an all-zero word, a fixed alternating word, or a programmable custom word, which lets a receiver align its bit and word framing. The select and the custom word take effect only when a new word is loaded. A word is therefore never cut short or mixed. The bit tick is a single-cycle enable in the block's only clock domain.

The sample input is a valid/ready stream. `s_ready` is high only in the cycle in which a word is loaded, which is the tick that ends the current word, and only when live data is selected. A beat is consumed when `s_valid` and `s_ready` are both high. A producer that holds `s_valid` high with stable data is back-pressured until that slot arrives. In training modes `s_ready` stays low and no beat is consumed. If the live slot arrives while `s_valid` is low, every lane sends an all-zero word for that slot.

Top module: `mser_top`

## Requirements
- R1: While reset is asserted and right after it, every serial line is 0, the word clock is 1, the bit clock is 0 and `s_ready` is 0. The first word after reset is all zeros.
- R2: The framing state moves only on a cycle with `bit_tick` high. Without a tick, the serial lines, the word clock and the bit clock hold their values.
- R3: The bits of a word go out least significant first. After the k-th tick of a word (k = 0 at the load), lane c shows bit k of its word.
- R4: The word clock is 1 while bits 0 to 5 of a word are on the lines and 0 while bits 6 to 11 are on the lines.
- R5: The bit clock toggles on every tick and on no other cycle.
- R6: With `train_sel` = 2'b00 (live), `s_ready` is high exactly on the tick that ends a word. An accepted beat gives lane c the field `s_data[12*c +: 12]`.
- R7: In live mode, a load tick with `s_valid` low sends an all-zero word on every lane.
- R8: `train_sel` = 2'b01 sends an all-zero word on every lane, and `s_ready` stays 0.
- R9: `train_sel` = 2'b10 sends the alternating word 12'hAAA (binary 101010101010) on every lane, so each word starts with a 0 bit.
- R10: `train_sel` = 2'b11 sends `custom_word` on every lane, using its value at the load tick.
- R11: A change of `train_sel` or `custom_word` in the middle of a word has no effect until the next load tick.
- R12: All eight lanes load and shift on the same ticks, so their word boundaries coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable that advances one serial bit |
| train_sel | input | 2 | 00 live, 01 zeros, 10 alternating, 11 custom |
| custom_word | input | 12 | Programmable training word |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat accepted at this word load |
| s_data | input | 96 | Eight 12-bit samples; lane c at bits 12c+11..12c |
| ser_dout | output | 8 | Serial data, one bit per lane |
| word_clk | output | 1 | Word framing clock, high for the first half of each word |
| bit_clk | output | 1 | Toggles once per transmitted bit |

## Verification
The assertions check the tick discipline on every cycle: the bit clock toggles only with a tick, and the serial lines hold between ticks. They compare the word clock phase against an independent count of ticks, confirm that `s_ready` rises only on a live-mode load tick, and confirm that a zero-pattern load gives silent lanes. The content of each word only shows up in the bench's cycle-by-cycle reference comparison. That covers bit ordering, per-lane field mapping, the alternating and custom patterns, underrun zero words, and a select change in the middle of a word deferring to the next boundary.

// File: rtl/mser_pkg.sv
package mser_pkg;
  typedef enum logic [1:0] {
    TS_LIVE   = 2'b00,
    TS_ZERO   = 2'b01,
    TS_ALT    = 2'b10,
    TS_CUSTOM = 2'b11
  } train_sel_e;
endpackage

// File: rtl/mser_frame_ctr.sv
module mser_frame_ctr #(
  parameter int W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  output logic [$clog2(W)-1:0]   bit_idx,
  output logic                   last_bit,
  output logic                   word_clk,
  output logic                   bit_clk
);
  localparam int IW   = $clog2(W);
  localparam int HALF = W / 2;

  logic [IW-1:0] idx_q;
  logic          bclk_q;

  assign last_bit = (idx_q == IW'(W - 1));
  assign bit_idx  = idx_q;
  assign word_clk = (idx_q < IW'(HALF));
  assign bit_clk  = bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      bclk_q <= ~bclk_q;
      if (last_bit) idx_q <= '0;
      else          idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/mser_pattern_mux.sv
module mser_pattern_mux
  import mser_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 12
) (
  input  logic [1:0]     sel,
  input  logic [W-1:0]   custom_word,
  input  logic           s_valid,
  input  logic [N*W-1:0] s_data,
  output logic [N*W-1:0] words
);
  function automatic logic [W-1:0] alt_word();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i % 2 == 1);
    return r;
  endfunction

  localparam logic [W-1:0] ALT = alt_word();

  for (genvar c = 0; c < N; c++) begin : g_lane
    always_comb begin
      unique case (train_sel_e'(sel))
        TS_LIVE:   words[c*W +: W] = s_valid ? s_data[c*W +: W] : '0;
        TS_ZERO:   words[c*W +: W] = '0;
        TS_ALT:    words[c*W +: W] = ALT;
        TS_CUSTOM: words[c*W +: W] = custom_word;
        default:   words[c*W +: W] = '0;
      endcase
    end
  end
endmodule

// File: rtl/mser_lane.sv
module mser_lane #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] word_in,
  output logic         dout
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= word_in;
    else if (tick)  shreg <= {1'b0, shreg[W-1:1]};
  end

  assign dout = shreg[0];
endmodule

// File: rtl/mser_top.sv
module mser_top
  import mser_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_tick,
  input  logic [1:0]     train_sel,
  input  logic [W-1:0]   custom_word,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [N*W-1:0] s_data,
  output logic [N-1:0]   ser_dout,
  output logic           word_clk,
  output logic           bit_clk
);
  localparam int IW = $clog2(W);

  logic [IW-1:0]  bit_idx;
  logic           last_bit;
  logic           load;
  logic [N*W-1:0] words;

  mser_frame_ctr #(.W(W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .bit_idx  (bit_idx),
    .last_bit (last_bit),
    .word_clk (word_clk),
    .bit_clk  (bit_clk)
  );

  assign load    = bit_tick & last_bit;
  assign s_ready = load & (train_sel_e'(train_sel) == TS_LIVE);

  mser_pattern_mux #(.N(N), .W(W)) u_mux (
    .sel         (train_sel),
    .custom_word (custom_word),
    .s_valid     (s_valid),
    .s_data      (s_data),
    .words       (words)
  );

  for (genvar c = 0; c < N; c++) begin : g_lane
    mser_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (bit_tick),
      .load    (load),
      .word_in (words[c*W +: W]),
      .dout    (ser_dout[c])
    );
  end

  logic unused_idx;
  assign unused_idx = ^bit_idx;
endmodule

// File: rtl/mser_chk.sv
module mser_chk #(
  parameter int N = 8,
  parameter int W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_tick,
  input logic [1:0]     train_sel,
  input logic [W-1:0]   custom_word,
  input logic           s_valid,
  input logic           s_ready,
  input logic [N*W-1:0] s_data,
  input logic [N-1:0]   ser_dout,
  input logic           word_clk,
  input logic           bit_clk
);
  localparam int IW   = $clog2(W);
  localparam int HALF = W / 2;

  logic [IW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (bit_tick) cnt <= (cnt == IW'(W - 1)) ? '0 : cnt + 1'b1;
  end

  assert_bclk_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (bit_clk != $past(bit_clk)));

  assert_bclk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(bit_clk));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(ser_dout) && $stable(word_clk)));

  assert_wclk_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_clk == (cnt < IW'(HALF)));

  assert_ready_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (bit_tick && cnt == IW'(W - 1) && train_sel == 2'b00));

  assert_zero_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && cnt == IW'(W - 1) && train_sel == 2'b01) |=> (ser_dout == '0));

  logic unused_in;
  assign unused_in = ^{custom_word, s_valid, s_data};
endmodule

bind mser_top mser_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/tb_mser_top.sv
`timescale 1ns/1ps
module tb_mser_top;
  localparam int N = 8;
  localparam int W = 12;
  localparam real CYC = 4.0;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bit_tick = 1'b0;
  logic [1:0]     train_sel = 2'b00;
  logic [W-1:0]   custom_word = '0;
  logic           s_valid = 1'b0;
  logic           s_ready;
  logic [N*W-1:0] s_data = '0;
  logic [N-1:0]   ser_dout;
  logic           word_clk;
  logic           bit_clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] mw [N];
  int           midx = 0;
  logic         mbclk = 1'b0;

  always #(CYC/2) clk = ~clk;

  mser_top #(.N(N), .W(W)) dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_dout();
    logic [N-1:0] r;
    for (int c = 0; c < N; c++) r[c] = mw[c][midx];
    return r;
  endfunction

  // Called at a negedge with inputs already driven; returns at the next negedge.
  task automatic cycle(string tag, logic tk);
    logic exp_rdy;
    logic hs;
    bit_tick = tk;
    #0.5;
    exp_rdy = tk && (midx == W - 1) && (train_sel == 2'b00);
    check(tag, 32'(s_ready), 32'(exp_rdy), "s_ready");
    hs = exp_rdy && s_valid;
    if (tk) begin
      mbclk = ~mbclk;
      if (midx == W - 1) begin
        midx = 0;
        for (int c = 0; c < N; c++) begin
          case (train_sel)
            2'b00: mw[c] = s_valid ? s_data[c*W +: W] : '0;
            2'b01: mw[c] = '0;
            2'b10: mw[c] = 12'hAAA;
            default: mw[c] = custom_word;
          endcase
        end
      end else begin
        midx++;
      end
    end
    @(posedge clk);
    #0.5;
    check(tag, 32'(ser_dout), 32'(exp_dout()), "ser_dout");
    check(tag, 32'(word_clk), 32'(midx < W/2), "word_clk");
    check(tag, 32'(bit_clk), 32'(mbclk), "bit_clk");
    @(negedge clk);
    if (hs) begin
      for (int c = 0; c < N; c++) s_data[c*W +: W] = W'($urandom);
    end
  endtask

  task automatic run(string tag, int ncyc, int tdiv);
    for (int i = 0; i < ncyc; i++) cycle(tag, (i % tdiv) == 0);
  endtask

  initial begin
    for (int c = 0; c < N; c++) mw[c] = '0;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check("R1", 32'(ser_dout), 32'h0, "ser_dout in reset");
    check("R1", 32'(word_clk), 32'h1, "word_clk in reset");
    check("R1", 32'(bit_clk), 32'h0, "bit_clk in reset");
    check("R1", 32'(s_ready), 32'h0, "s_ready in reset");
    rst_n = 1'b1;
    // R1: first word after reset is zeros even with data offered
    for (int c = 0; c < N; c++) s_data[c*W +: W] = W'(c * 273 + 5);
    s_valid = 1'b1;
    run("R1", W, 1);
    // R3 R4 R5 R6 R12: live data, a tick every cycle
    run("R6", W * 6, 1);
    // R2: sparse ticks, outputs hold between them
    run("R2", W * 3 * 3, 3);
    // R7: no valid beat at the load
    s_valid = 1'b0;
    run("R7", W * 2, 1);
    s_valid = 1'b1;
    run("R3", W * 2, 1);
    // R8: zero pattern, ready stays low
    train_sel = 2'b01;
    run("R8", W * 3, 1);
    // R9: alternating pattern
    train_sel = 2'b10;
    run("R9", W * 3, 1);
    // R10: custom pattern
    train_sel = 2'b11;
    custom_word = 12'h5C3;
    run("R10", W * 2, 1);
    custom_word = 12'h0F1;
    run("R10", W * 2, 2);
    // R11: mid-word changes take effect only at the next load
    run("R11", 5, 1);
    train_sel = 2'b10;
    custom_word = 12'hFFF;
    run("R11", 4, 1);
    train_sel = 2'b11;
    run("R11", W * 2, 1);
    run("R11", 3, 1);
    train_sel = 2'b00;
    run("R11", W * 3, 1);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CYC * 150000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule